// File: doc/BRIEF.md
# Scratchpad Memory Responder for an Uncached Request Bus

This block is a bus slave that sits behind a request/response bus with two channels. The request channel carries a message, a byte address, a byte mask and a 64-bit data beat. The response channel returns an acknowledgement, which is either plain or carries read data. The block serves a small 32-bit scratchpad at a fixed base address. It understands three request kinds: a read, a whole-word write and a masked write. It answers each one with the requester's tag and size copied back.

The storage is narrower than the data channel. Only the low 32 bits of a beat and the low four mask lanes can refer to real storage. Read replies always carry zero in the upper half. The bus has no timeout, so the block replies to every request it accepts. This includes addresses outside the scratchpad, misaligned addresses, writes that touch the upper half and message codes it does not support. All of these get a reply with the denied flag set, and they do not change the storage.

The block keeps only one request in flight. It accepts a request, presents the reply in the next cycle, and holds the reply until the requester takes it. The request channel stays closed during that time.

Top module: `spad_responder`

## Requirements
- R1: After reset, `a_ready` is 1, `d_valid` is 0, and every scratchpad word reads back as zero.
- R2: A request is accepted on a clock edge where `a_valid` and `a_ready` are both 1. `d_valid` is 1 in the following cycle. While `d_valid` is 1, `a_ready` is 0 and all response fields hold steady. `d_valid` falls after the edge where `d_ready` is 1.
- R3: Request code 4 (read) is answered with response code 1 (ack with data). The addressed word is placed in `d_data[31:0]`.
- R4: Request code 0 (whole write) and request code 1 (masked write) are both answered with response code 0 (ack) and `d_data` equal to zero. Byte lane i, meaning bits 8i+7..8i, is written only where `a_mask[i]` is 1, for i from 0 to 3.
- R5: `d_source` and `d_size` equal the accepted request's `a_source` and `a_size`. `d_param` is 0 and `d_corrupt` is 0 in every response.
- R6: Word k lives at byte address `BASE_ADDR + 4*k`, for k from 0 to `DEPTH_WORDS-1`. An address outside that span, or with bits [1:0] not zero, is answered with `d_denied` set to 1 and `d_data` equal to zero, and it changes no storage.
- R7: A write whose `a_mask[7:4]` is not zero, or whose `a_data[63:32]` is not zero, is answered with `d_denied` set to 1 and leaves the storage unchanged.
- R8: Any request code other than 0, 1 and 4 gets response code 0 with `d_denied` set to 1, and changes no storage.
- R9: `d_data[63:32]` is zero in every response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Request present |
| a_ready | output | 1 | Request can be taken |
| a_opcode | input | 3 | Request code (0 whole write, 1 masked write, 4 read) |
| a_size | input | SIZE_W (4) | Request size, echoed back |
| a_source | input | SRC_W (4) | Requester tag, echoed back |
| a_address | input | ADDR_W (32) | Byte address |
| a_mask | input | DATA_W/8 (8) | Byte-lane enables |
| a_data | input | DATA_W (64) | Write data |
| d_valid | output | 1 | Response present |
| d_ready | input | 1 | Response taken |
| d_opcode | output | 3 | Response code (0 ack, 1 ack with data) |
| d_param | output | 2 | Always zero |
| d_size | output | SIZE_W (4) | Copy of the request size |
| d_source | output | SRC_W (4) | Copy of the requester tag |
| d_denied | output | 1 | Request refused, no effect |
| d_data | output | DATA_W (64) | Read data, upper half zero |
| d_corrupt | output | 1 | Always zero |

## Verification
The bench builds the block with `DEPTH_WORDS` = 16 and the default base of 0x8000_0000. With 16 words, both the last word at base+0x3C and the first address past the end at base+0x40 are exercised directly, as is the word just below the base. The default 32-bit address and 64-bit data widths keep the upper data half and upper mask lanes present, so the refusal of writes that touch them can be driven. Back-pressure on the response channel is applied for several cycles while a second request is offered, to show that the second request is neither taken nor written.

// File: rtl/spad_pkg.sv
// Package: shared message codes and request classes for the scratchpad responder.
// Assumes the uncached request/response code values listed in the brief.
package spad_pkg;
    localparam logic [2:0] A_WRITE_FULL = 3'd0;
    localparam logic [2:0] A_WRITE_PART = 3'd1;
    localparam logic [2:0] A_READ       = 3'd4;
    localparam logic [2:0] D_ACK        = 3'd0;
    localparam logic [2:0] D_ACK_DATA   = 3'd1;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_OTHER = 2'd2
    } req_kind_e;
endpackage

// File: rtl/spad_req_decode.sv
// Request decoder: classifies the request code, checks the address span and
// alignment, and refuses writes that touch the channel half beyond the word.
// Assumes DATA_W > WORD_W and DEPTH_WORDS a power of two (at least 2).
module spad_req_decode
    import spad_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int WORD_W      = 32,
    parameter int DEPTH_WORDS = 256,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
    localparam int BUS_LANES  = DATA_W / 8,
    localparam int WORD_LANES = WORD_W / 8,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic [2:0]            opcode,
    input  logic [ADDR_W-1:0]     address,
    input  logic [BUS_LANES-1:0]  mask,
    input  logic [DATA_W-1:0]     data,
    output req_kind_e             kind,
    output logic                  denied,
    output logic [IDX_W-1:0]      index,
    output logic [WORD_LANES-1:0] lanes,
    output logic [WORD_W-1:0]     word
);
    localparam int OFF_LSB = $clog2(WORD_LANES);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(DEPTH_WORDS * WORD_LANES);

    logic [ADDR_W-1:0] offset;
    logic              in_span;
    logic              aligned;
    logic              upper_clean;

    // Classify the request code.
    always_comb begin
        case (opcode)
            A_READ:                     kind = KIND_READ;
            A_WRITE_FULL, A_WRITE_PART: kind = KIND_WRITE;
            default:                    kind = KIND_OTHER;
        endcase
    end

    // Locate the address relative to the scratchpad and check the unused half.
    always_comb begin
        offset      = address - BASE_ADDR;
        in_span     = offset < SPAN;
        aligned     = address[OFF_LSB-1:0] == '0;
        upper_clean = (mask[BUS_LANES-1:WORD_LANES] == '0) &&
                      (data[DATA_W-1:WORD_W] == '0);
    end

    // Decide refusal and pick out word index, lanes and write word.
    always_comb begin
        case (kind)
            KIND_READ:  denied = !(in_span && aligned);
            KIND_WRITE: denied = !(in_span && aligned && upper_clean);
            default:    denied = 1'b1;
        endcase
        index = offset[OFF_LSB +: IDX_W];
        lanes = mask[WORD_LANES-1:0];
        word  = data[WORD_W-1:0];
    end
endmodule

// File: rtl/spad_store.sv
// Scratchpad storage: DEPTH_WORDS words of WORD_W bits, cleared by reset,
// asynchronous read at the request index, byte-lane masked write on the edge.
// Assumes the caller only raises wr_en for an index inside the array.
module spad_store #(
    parameter int WORD_W      = 32,
    parameter int DEPTH_WORDS = 256,
    localparam int WORD_LANES = WORD_W / 8,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      index,
    input  logic [WORD_LANES-1:0] lanes,
    input  logic [WORD_W-1:0]     wr_word,
    output logic [WORD_W-1:0]     rd_word
);
    logic [WORD_W-1:0] mem [DEPTH_WORDS];
    logic [WORD_W-1:0] merged;

    // Read the addressed word.
    assign rd_word = mem[index];

    // Per lane, take new data where enabled and keep the old byte elsewhere.
    for (genvar g = 0; g < WORD_LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lanes[g] ? wr_word[g*8 +: 8] : rd_word[g*8 +: 8];
    end

    // Clear on reset, otherwise store the merged word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[index] <= merged;
        end
    end
endmodule

// File: rtl/spad_resp_reg.sv
// Response holding register: loads one response when a request is accepted
// and holds it until the requester takes it.
// Assumes load is never raised while a response is still held.
module spad_resp_reg #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 4,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic [2:0]        opcode_in,
    input  logic [SIZE_W-1:0] size_in,
    input  logic [SRC_W-1:0]  source_in,
    input  logic              denied_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid,
    output logic [2:0]        opcode,
    output logic [SIZE_W-1:0] size,
    output logic [SRC_W-1:0]  source,
    output logic              denied,
    output logic [DATA_W-1:0] data
);
    // Capture on load, drop valid once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            opcode <= '0;
            size   <= '0;
            source <= '0;
            denied <= 1'b0;
            data   <= '0;
        end else if (load) begin
            valid  <= 1'b1;
            opcode <= opcode_in;
            size   <= size_in;
            source <= source_in;
            denied <= denied_in;
            data   <= data_in;
        end else if (take) begin
            valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/spad_responder.sv
// Scratchpad responder top: takes one uncached request at a time, reads or
// masked-writes the 32-bit scratchpad, and replies on the response channel.
// Every accepted request gets exactly one reply; refused ones are flagged.
// Assumes the requester holds request fields stable while a_valid is high.
module spad_responder
    import spad_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int WORD_W      = 32,
    parameter int SRC_W       = 4,
    parameter int SIZE_W      = 4,
    parameter int DEPTH_WORDS = 256,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_valid,
    output logic                a_ready,
    input  logic [2:0]          a_opcode,
    input  logic [SIZE_W-1:0]   a_size,
    input  logic [SRC_W-1:0]    a_source,
    input  logic [ADDR_W-1:0]   a_address,
    input  logic [DATA_W/8-1:0] a_mask,
    input  logic [DATA_W-1:0]   a_data,
    output logic                d_valid,
    input  logic                d_ready,
    output logic [2:0]          d_opcode,
    output logic [1:0]          d_param,
    output logic [SIZE_W-1:0]   d_size,
    output logic [SRC_W-1:0]    d_source,
    output logic                d_denied,
    output logic [DATA_W-1:0]   d_data,
    output logic                d_corrupt
);
    localparam int WORD_LANES = WORD_W / 8;
    localparam int IDX_W      = $clog2(DEPTH_WORDS);

    req_kind_e             kind;
    logic                  refuse;
    logic [IDX_W-1:0]      index;
    logic [WORD_LANES-1:0] lanes;
    logic [WORD_W-1:0]     wr_word;
    logic [WORD_W-1:0]     rd_word;
    logic                  accept;
    logic                  write_go;
    logic [2:0]            rsp_opcode;
    logic [DATA_W-1:0]     rsp_data;

    spad_req_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W),
        .DEPTH_WORDS(DEPTH_WORDS), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .opcode(a_opcode), .address(a_address), .mask(a_mask), .data(a_data),
        .kind(kind), .denied(refuse), .index(index), .lanes(lanes), .word(wr_word)
    );

    spad_store #(.WORD_W(WORD_W), .DEPTH_WORDS(DEPTH_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(write_go), .index(index),
        .lanes(lanes), .wr_word(wr_word), .rd_word(rd_word)
    );

    // Request channel opens only when no reply is waiting.
    assign a_ready  = !d_valid;
    assign accept   = a_valid && a_ready;
    assign write_go = accept && (kind == KIND_WRITE) && !refuse;

    // Form the reply code and data for the request being accepted.
    always_comb begin
        rsp_opcode = (kind == KIND_READ) ? D_ACK_DATA : D_ACK;
        rsp_data   = '0;
        if (kind == KIND_READ && !refuse) rsp_data[WORD_W-1:0] = rd_word;
    end

    spad_resp_reg #(.DATA_W(DATA_W), .SRC_W(SRC_W), .SIZE_W(SIZE_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .load(accept), .take(d_ready),
        .opcode_in(rsp_opcode), .size_in(a_size), .source_in(a_source),
        .denied_in(refuse), .data_in(rsp_data),
        .valid(d_valid), .opcode(d_opcode), .size(d_size), .source(d_source),
        .denied(d_denied), .data(d_data)
    );

    // Fixed reply fields.
    assign d_param   = 2'b00;
    assign d_corrupt = 1'b0;
endmodule

// File: rtl/spad_responder_chk.sv
// Checker for spad_responder: channel handshake and reply-field properties.
// Attached to every instance of the top module through bind.
module spad_responder_chk #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    parameter int SRC_W  = 4,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_valid,
    input logic              a_ready,
    input logic [2:0]        a_opcode,
    input logic [SIZE_W-1:0] a_size,
    input logic [SRC_W-1:0]  a_source,
    input logic              d_valid,
    input logic              d_ready,
    input logic [2:0]        d_opcode,
    input logic [1:0]        d_param,
    input logic [SIZE_W-1:0] d_size,
    input logic [SRC_W-1:0]  d_source,
    input logic              d_denied,
    input logic [DATA_W-1:0] d_data,
    input logic              d_corrupt
);
    p_reply_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |=> d_valid);
    p_closed_while_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> !a_ready);
    p_reply_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_data) && $stable(d_opcode) &&
                                   $stable(d_source) && $stable(d_denied)));
    p_read_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready && a_opcode == 3'd4) |=> d_opcode == 3'd1);
    p_ack_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_opcode == 3'd0) |-> d_data == '0);
    p_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |=> (d_source == $past(a_source) && d_size == $past(a_size)));
    p_fixed_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (d_param == 2'b00 && !d_corrupt));
    p_denied_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_denied) |-> d_data == '0);
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> d_data[DATA_W-1:WORD_W] == '0);
endmodule

bind spad_responder spad_responder_chk #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .SRC_W(SRC_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_ready(a_ready),
    .a_opcode(a_opcode), .a_size(a_size), .a_source(a_source),
    .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode), .d_param(d_param),
    .d_size(d_size), .d_source(d_source), .d_denied(d_denied), .d_data(d_data),
    .d_corrupt(d_corrupt)
);

// File: tb/sim_spad_responder.sv
`timescale 1ns/1ps
module sim_spad_responder;
    localparam int DEPTH = 16;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0;
    logic        a_ready;
    logic [2:0]  a_opcode = '0;
    logic [3:0]  a_size = '0;
    logic [3:0]  a_source = '0;
    logic [31:0] a_address = '0;
    logic [7:0]  a_mask = '0;
    logic [63:0] a_data = '0;
    logic        d_valid;
    logic        d_ready = 1'b0;
    logic [2:0]  d_opcode;
    logic [1:0]  d_param;
    logic [3:0]  d_size;
    logic [3:0]  d_source;
    logic        d_denied;
    logic [63:0] d_data;
    logic        d_corrupt;

    spad_responder #(.DEPTH_WORDS(DEPTH), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_ready(a_ready),
        .a_opcode(a_opcode), .a_size(a_size), .a_source(a_source),
        .a_address(a_address), .a_mask(a_mask), .a_data(a_data),
        .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
        .d_param(d_param), .d_size(d_size), .d_source(d_source),
        .d_denied(d_denied), .d_data(d_data), .d_corrupt(d_corrupt)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit exp_busy = 1'b0;
    logic [31:0] mdl [DEPTH];
    logic [2:0]  e_op;
    logic        e_den;
    logic [63:0] e_dat;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model: decide the reply and update the model storage.
    task automatic predict(input logic [2:0] op, input logic [31:0] addr,
                           input logic [7:0] mask, input logic [63:0] data);
        logic [31:0] off;
        bit inr;
        int k;
        off = addr - BASE;
        inr = (off < DEPTH * 4) && (addr[1:0] == 2'b00);
        k = int'(off >> 2);
        e_dat = '0;
        if (op == 3'd4) begin
            e_op = 3'd1;
            e_den = !inr;
            if (inr) e_dat = {32'h0, mdl[k]};
        end else if (op == 3'd0 || op == 3'd1) begin
            e_op = 3'd0;
            e_den = !(inr && mask[7:4] == 4'h0 && data[63:32] == 32'h0);
            if (!e_den)
                for (int b = 0; b < 4; b++)
                    if (mask[b]) mdl[k][b*8 +: 8] = data[b*8 +: 8];
        end else begin
            e_op = 3'd0;
            e_den = 1'b1;
        end
    endtask

    task automatic check_reply(input string req, input logic [3:0] src, input logic [3:0] sz);
        chk(d_valid === 1'b1, "R2", "d_valid", 64'(d_valid), 64'd1);
        chk(d_opcode === e_op, req, "d_opcode", 64'(d_opcode), 64'(e_op));
        chk(d_denied === e_den, req, "d_denied", 64'(d_denied), 64'(e_den));
        chk(d_data === e_dat, req, "d_data", d_data, e_dat);
        chk(d_data[63:32] === 32'h0, "R9", "d_data upper", 64'(d_data[63:32]), 64'd0);
        chk(d_source === src && d_size === sz, "R5", "source/size",
            {56'h0, d_source, d_size}, {56'h0, src, sz});
        chk(d_param === 2'b00 && d_corrupt === 1'b0, "R5", "param/corrupt",
            {61'h0, d_param, d_corrupt}, 64'd0);
    endtask

    // One transaction; optionally stall the reply and offer a second request meanwhile.
    task automatic xact(input string req, input logic [2:0] op, input logic [31:0] addr,
                        input logic [7:0] mask, input logic [63:0] data,
                        input logic [3:0] src, input logic [3:0] sz,
                        input int stall, input bit intrude);
        @(negedge clk);
        a_opcode = op; a_address = addr; a_mask = mask; a_data = data;
        a_source = src; a_size = sz; a_valid = 1'b1;
        @(posedge clk); #1;
        a_valid = 1'b0;
        predict(op, addr, mask, data);
        exp_busy = 1'b1;
        @(negedge clk);
        check_reply(req, src, sz);
        for (int s = 0; s < stall; s++) begin
            if (intrude) begin
                a_opcode = 3'd0; a_address = BASE + 32'h10; a_mask = 8'h0F;
                a_data = 64'h77; a_source = 4'hE; a_valid = 1'b1;
            end
            @(negedge clk);
            check_reply("R2", src, sz);
        end
        a_valid = 1'b0;
        d_ready = 1'b1;
        @(posedge clk); #1;
        d_ready = 1'b0;
        exp_busy = 1'b0;
    endtask

    // Per-cycle comparison of channel state against the model's expectation.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(d_valid === exp_busy, "R2", "d_valid per cycle", 64'(d_valid), 64'(exp_busy));
            chk(a_ready === !exp_busy, "R2", "a_ready per cycle", 64'(a_ready), 64'(!exp_busy));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(a_ready === 1'b1 && d_valid === 1'b0, "R1", "reset handshake",
            {62'h0, a_ready, d_valid}, 64'h2);
        // R1: storage reads zero after reset
        xact("R1", 3'd4, BASE, 8'h0F, 64'h0, 4'h1, 4'h2, 0, 1'b0);
        xact("R1", 3'd4, BASE + 32'h3C, 8'h0F, 64'h0, 4'h2, 4'h2, 0, 1'b0);
        // R4 / R3: whole write then masked write, read back
        xact("R4", 3'd0, BASE, 8'h0F, 64'hDEAD_BEEF, 4'h3, 4'h2, 0, 1'b0);
        xact("R3", 3'd4, BASE, 8'h0F, 64'h0, 4'h4, 4'h2, 0, 1'b0);
        xact("R4", 3'd1, BASE, 8'h05, 64'h1122_3344, 4'h5, 4'h2, 0, 1'b0);
        xact("R3", 3'd4, BASE, 8'h0F, 64'h0, 4'h6, 4'h2, 0, 1'b0);
        xact("R4", 3'd1, BASE + 32'h3C, 8'h0A, 64'hAABB_CCDD, 4'h7, 4'h1, 0, 1'b0);
        xact("R3", 3'd4, BASE + 32'h3C, 8'h0F, 64'h0, 4'h8, 4'h2, 0, 1'b0);
        // R6: outside the span, below the base, misaligned
        xact("R6", 3'd4, BASE + 32'h40, 8'h0F, 64'h0, 4'h9, 4'h2, 0, 1'b0);
        xact("R6", 3'd0, BASE + 32'h40, 8'h0F, 64'h1234, 4'hA, 4'h2, 0, 1'b0);
        xact("R6", 3'd4, BASE - 32'h4, 8'h0F, 64'h0, 4'hB, 4'h2, 0, 1'b0);
        xact("R6", 3'd0, 32'h0, 8'h0F, 64'h55, 4'hC, 4'h2, 0, 1'b0);
        xact("R6", 3'd0, BASE + 32'h1, 8'h0F, 64'h99, 4'hD, 4'h2, 0, 1'b0);
        xact("R6", 3'd4, BASE, 8'h0F, 64'h0, 4'h0, 4'h2, 0, 1'b0);
        // R7: upper lanes or upper data on a write
        xact("R7", 3'd1, BASE + 32'h4, 8'h10, 64'h0000_00FF_0000_0000, 4'h1, 4'h3, 0, 1'b0);
        xact("R7", 3'd0, BASE + 32'h4, 8'h0F, 64'h0000_0001_0000_0055, 4'h2, 4'h2, 0, 1'b0);
        xact("R7", 3'd4, BASE + 32'h4, 8'h0F, 64'h0, 4'h3, 4'h2, 0, 1'b0);
        // R8: unsupported request codes
        xact("R8", 3'd2, BASE + 32'h8, 8'h0F, 64'h66, 4'h4, 4'h2, 0, 1'b0);
        xact("R8", 3'd5, BASE + 32'h8, 8'h0F, 64'h66, 4'h5, 4'h2, 0, 1'b0);
        xact("R8", 3'd4, BASE + 32'h8, 8'h0F, 64'h0, 4'h6, 4'h2, 0, 1'b0);
        // R2: held reply with a second request offered meanwhile
        xact("R2", 3'd0, BASE + 32'hC, 8'h0F, 64'h0BAD_F00D, 4'hF, 4'h2, 3, 1'b1);
        xact("R2", 3'd4, BASE + 32'h10, 8'h0F, 64'h0, 4'h7, 4'h2, 0, 1'b0);
        xact("R2", 3'd4, BASE + 32'hC, 8'h0F, 64'h0, 4'h8, 4'h2, 2, 1'b0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule